// File: doc/BRIEF.md
# Frame-Synced Dual-Frame Serial Data Port

This block is the processor-facing end of a converter interface. The link uses a bit clock, an active-low frame sync, a data-out line with its own output enable, and a data-in line. Each frame carries one 16-bit word in each direction, sent MSB first. Frames alternate between two kinds. A **primary** frame sends the current ADC conversion result on the data-out line and collects a DAC sample from the data-in line. A **secondary** frame collects a control word. That word either writes a configuration register or asks to read one, and the data for a read goes out in the following secondary frame.

The port runs in a fast system clock domain. It oversamples the bit clock, frame sync and data-in through a synchronizer, then acts on the detected edges. It does not generate the bit clock or the frame sync. Register storage is outside the block: writes leave through a one-cycle strobe with address and data, and reads use a read-address output and a read-data input.

The output enable is the tri-state control for the data-out pin. While it is low, the data-out port is driven to zero.

Top module: `sport_serial_port`

## Requirements
- R1: After reset, the output enable, data-out, the DAC strobe and the register write strobe are all 0, and the first frame that follows is a primary frame.
- R2: A falling edge of the frame sync raises the output enable, and data-out then shows bit 15 of the word for that frame.
- R3: Each rising bit-clock edge inside a frame advances data-out by one bit, MSB first, so rising edge k shows bit 15-k for k = 1 to 15. Data-out does not change between rising edges.
- R4: The output enable falls on the 16th rising bit-clock edge after the frame-sync falling edge. It stays low, with data-out at 0, until the next frame-sync falling edge.
- R5: In a primary frame, the word sent is the ADC input as sampled at the frame-sync falling edge.
- R6: Data-in is captured on falling bit-clock edges, MSB first. In a primary frame, the 16th falling edge raises the DAC strobe for exactly one system clock and updates the DAC word output, which then holds its value.
- R7: Frame kinds alternate strictly: primary, secondary, primary, and so on.
- R8: A secondary word with bit 13 = 0 is a write. It gives exactly one register write strobe, with address = bits 12:8 and data = bits 7:0, and no DAC strobe. Bits 15:14 are ignored.
- R9: A secondary word with bit 13 = 1 is a read. It gives no write strobe, it sets the read-address output to bits 12:8, and the next secondary frame sends {8'h00, read data}.
- R10: A secondary frame that has no pending read sends all zeros, and a read is sent only once.
- R11: Bit-clock edges while no frame is active leave the output enable low and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| fs_n_i | input | 1 | Active-low frame sync |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out (0 when not enabled) |
| dout_oe_o | output | 1 | Output enable of the data-out driver |
| adc_word_i | input | 16 | ADC result sent in primary frames |
| dac_word_o | output | 16 | Last DAC sample received |
| dac_valid_o | output | 1 | One-cycle strobe for a new DAC sample |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | 5 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | 5 | Register read address |
| reg_rdata_i | input | 8 | Register read data |

## Verification
The assertions check the driver behaviour on every cycle. The enable may only rise right after a detected frame-sync edge. Data-out must hold between rising bit-clock edges and must be zero whenever the driver is disabled. Both strobes must be single-cycle pulses and may never be active together. The bench scenarios are needed for the behaviour that depends on words and frame history: exact bit order, the 16th-edge release, the alternation of frame kinds, field decoding of the control word, and the one-frame delay and zero padding of read data.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial port. Assumes nothing beyond the standard.
package sport_pkg;
    typedef enum logic {
        FRM_PRIMARY   = 1'b0,
        FRM_SECONDARY = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/sport_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes bit clock, frame sync and data-in into clk and flags edges.
// Assumes STAGES >= 2 and that each serial level lasts several clk cycles.
// All three inputs go through the same depth, so they keep their alignment.
module sport_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fs_n_i,
    input  logic din_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic fs_fall_o,
    output logic din_s_o
);
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] fs_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              sclk_last;
    logic              fs_last;

    // Purpose: shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            fs_pipe   <= '1;
            din_pipe  <= '0;
            sclk_last <= 1'b0;
            fs_last   <= 1'b1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
            fs_pipe   <= {fs_pipe[STAGES-2:0], fs_n_i};
            din_pipe  <= {din_pipe[STAGES-2:0], din_i};
            sclk_last <= sclk_pipe[STAGES-1];
            fs_last   <= fs_pipe[STAGES-1];
        end
    end

    // Purpose: compare the synchronized level with its previous value.
    always_comb begin
        sclk_rise_o = sclk_pipe[STAGES-1] & ~sclk_last;
        sclk_fall_o = ~sclk_pipe[STAGES-1] & sclk_last;
        fs_fall_o   = ~fs_pipe[STAGES-1] & fs_last;
        din_s_o     = din_pipe[STAGES-1];
    end
endmodule

// File: rtl/sport_tx_shifter.sv
`timescale 1ns/1ps
// Transmit path: loads a word on frame start and shifts it out MSB first,
// one bit per rising bit-clock edge. It releases the driver on the
// WORD_W-th rising edge. Assumes the edge flags are one-cycle pulses.
module sport_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_fall_i,
    input  logic              sclk_rise_i,
    input  logic [WORD_W-1:0] load_word_i,
    output logic              dout_o,
    output logic              dout_oe_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  rise_cnt;
    logic              oe_q;

    // Purpose: load on frame start, shift on rising edges, stop at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            rise_cnt <= '0;
            oe_q     <= 1'b0;
        end else if (fs_fall_i) begin
            sreg     <= load_word_i;
            rise_cnt <= '0;
            oe_q     <= 1'b1;
        end else if (oe_q && sclk_rise_i) begin
            if (rise_cnt == CNT_W'(WORD_W - 1)) begin
                oe_q     <= 1'b0;
                rise_cnt <= '0;
                sreg     <= '0;
            end else begin
                sreg     <= {sreg[WORD_W-2:0], 1'b0};
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // Purpose: drive the MSB only while the driver is enabled.
    always_comb begin
        dout_oe_o = oe_q;
        dout_o    = oe_q & sreg[WORD_W-1];
    end
endmodule

// File: rtl/sport_rx_shifter.sv
`timescale 1ns/1ps
// Receive path: collects WORD_W bits of data-in on falling bit-clock edges,
// MSB first, after a frame start. It pulses done for one cycle when the
// word is complete. Falling edges outside a frame are ignored.
module sport_rx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_fall_i,
    input  logic              sclk_fall_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  fall_cnt;
    logic              active;

    // Purpose: shift in data-in and flag the completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            fall_cnt <= '0;
            active   <= 1'b0;
            word_o   <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (fs_fall_i) begin
                active   <= 1'b1;
                fall_cnt <= '0;
            end else if (active && sclk_fall_i) begin
                sreg <= {sreg[WORD_W-2:0], din_i};
                if (fall_cnt == CNT_W'(WORD_W - 1)) begin
                    word_o   <= {sreg[WORD_W-2:0], din_i};
                    done_o   <= 1'b1;
                    active   <= 1'b0;
                    fall_cnt <= '0;
                end else begin
                    fall_cnt <= fall_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sport_frame_ctl.sv
`timescale 1ns/1ps
// Frame controller: tracks whether a frame is primary or secondary, picks
// the word to send, and turns received words into DAC or register actions.
// A read request is kept pending until the next secondary frame sends it.
module sport_frame_ctl
    import sport_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int RW_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_fall_i,
    input  logic              rx_done_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic [WORD_W-1:0] adc_word_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic [WORD_W-1:0] tx_word_o,
    output logic [WORD_W-1:0] dac_word_o,
    output logic              dac_valid_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_waddr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic [ADDR_W-1:0] reg_raddr_o
);
    localparam int PAD_W = WORD_W - DATA_W;

    frame_kind_e       cur_kind;
    frame_kind_e       next_kind;
    logic              rd_pending;
    logic [ADDR_W-1:0] field_addr;
    logic [DATA_W-1:0] field_data;
    logic              field_rd;

    // Purpose: split the control word into its fields.
    always_comb begin
        field_rd   = rx_word_i[RW_BIT];
        field_addr = rx_word_i[RW_BIT-1 -: ADDR_W];
        field_data = rx_word_i[DATA_W-1:0];
    end

    // Purpose: choose the word to send in the frame that is starting.
    always_comb begin
        if (next_kind == FRM_PRIMARY) begin
            tx_word_o = adc_word_i;
        end else if (rd_pending) begin
            tx_word_o = {{PAD_W{1'b0}}, reg_rdata_i};
        end else begin
            tx_word_o = '0;
        end
    end

    // Purpose: advance the frame kind and act on completed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind    <= FRM_PRIMARY;
            next_kind   <= FRM_PRIMARY;
            rd_pending  <= 1'b0;
            dac_word_o  <= '0;
            dac_valid_o <= 1'b0;
            reg_we_o    <= 1'b0;
            reg_waddr_o <= '0;
            reg_wdata_o <= '0;
            reg_raddr_o <= '0;
        end else begin
            dac_valid_o <= 1'b0;
            reg_we_o    <= 1'b0;
            if (fs_fall_i) begin
                cur_kind  <= next_kind;
                next_kind <= (next_kind == FRM_PRIMARY) ? FRM_SECONDARY : FRM_PRIMARY;
                if (next_kind == FRM_SECONDARY) begin
                    rd_pending <= 1'b0;
                end
            end else if (rx_done_i) begin
                if (cur_kind == FRM_PRIMARY) begin
                    dac_word_o  <= rx_word_i;
                    dac_valid_o <= 1'b1;
                end else if (field_rd) begin
                    rd_pending  <= 1'b1;
                    reg_raddr_o <= field_addr;
                end else begin
                    reg_we_o    <= 1'b1;
                    reg_waddr_o <= field_addr;
                    reg_wdata_o <= field_data;
                end
            end
        end
    end
endmodule

// File: rtl/sport_serial_port.sv
`timescale 1ns/1ps
// Top of the dual-frame serial port. Wires the synchronizer, the transmit
// and receive shifters and the frame controller together. Assumes the
// bit clock is well below clk / (2 * (SYNC_STAGES + 2)).
module sport_serial_port #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int RW_BIT      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fs_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    input  logic [WORD_W-1:0] adc_word_i,
    output logic [WORD_W-1:0] dac_word_o,
    output logic              dac_valid_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_waddr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic [ADDR_W-1:0] reg_raddr_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    logic              sclk_rise_w;
    logic              sclk_fall_w;
    logic              fs_fall_w;
    logic              din_s_w;
    logic [WORD_W-1:0] rx_word_w;
    logic              rx_done_w;
    logic [WORD_W-1:0] tx_word_w;

    sport_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk_i), .fs_n_i(fs_n_i), .din_i(din_i),
        .sclk_rise_o(sclk_rise_w), .sclk_fall_o(sclk_fall_w),
        .fs_fall_o(fs_fall_w), .din_s_o(din_s_w)
    );

    sport_tx_shifter #(.WORD_W(WORD_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .fs_fall_i(fs_fall_w), .sclk_rise_i(sclk_rise_w),
        .load_word_i(tx_word_w),
        .dout_o(dout_o), .dout_oe_o(dout_oe_o)
    );

    sport_rx_shifter #(.WORD_W(WORD_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .fs_fall_i(fs_fall_w), .sclk_fall_i(sclk_fall_w),
        .din_i(din_s_w),
        .word_o(rx_word_w), .done_o(rx_done_w)
    );

    sport_frame_ctl #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_BIT(RW_BIT)
    ) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .fs_fall_i(fs_fall_w), .rx_done_i(rx_done_w), .rx_word_i(rx_word_w),
        .adc_word_i(adc_word_i), .reg_rdata_i(reg_rdata_i),
        .tx_word_o(tx_word_w),
        .dac_word_o(dac_word_o), .dac_valid_o(dac_valid_o),
        .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o),
        .reg_wdata_o(reg_wdata_o), .reg_raddr_o(reg_raddr_o)
    );
endmodule

// File: rtl/sport_serial_port_chk.sv
`timescale 1ns/1ps
// Property checker for the serial port, attached to the top through bind.
// It watches the synchronizer edge flags and the top-level outputs.
module sport_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic fs_fall,
    input logic sclk_rise,
    input logic dout_o,
    input logic dout_oe_o,
    input logic dac_valid_o,
    input logic reg_we_o
);
    // R2: the driver turns on only right after a frame-sync falling edge
    a_r2_oe_rise_after_fs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe_o) |-> $past(fs_fall));

    // R3: data-out only moves after a rising bit-clock edge or a frame start
    a_r3_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && $past(dout_oe_o) && !$past(sclk_rise) && !$past(fs_fall))
        |-> $stable(dout_o));

    // R4: data-out is low whenever the driver is off
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> (dout_o == 1'b0));

    // R6: the DAC strobe lasts one cycle
    a_r6_dac_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid_o |=> !dac_valid_o);

    // R8: the write strobe lasts one cycle
    a_r8_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R8: a frame gives a DAC strobe or a write strobe, never both
    a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_valid_o && reg_we_o));
endmodule

bind sport_serial_port sport_serial_port_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .fs_fall(fs_fall_w), .sclk_rise(sclk_rise_w),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .dac_valid_o(dac_valid_o), .reg_we_o(reg_we_o)
);

// File: tb/sport_serial_port_tb.sv
`timescale 1ns/1ps
// Directed bench for the serial port: one task per scenario.
module sport_serial_port_tb_top;
    localparam int HALF = 8;   // clk cycles per bit-clock half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        fs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout, dout_oe;
    logic [15:0] adc_word = 16'h0;
    logic [15:0] dac_word;
    logic        dac_valid, reg_we;
    logic [4:0]  reg_waddr, reg_raddr;
    logic [7:0]  reg_wdata, reg_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int dac_pulses = 0;
    int we_pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Bench register file model: read data depends only on the address.
    function automatic logic [7:0] rd_model(input logic [4:0] a);
        return {3'b110, a} ^ 8'h5A;
    endfunction
    assign reg_rdata = rd_model(reg_raddr);

    sport_serial_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk), .fs_n_i(fs_n), .din_i(din),
        .dout_o(dout), .dout_oe_o(dout_oe),
        .adc_word_i(adc_word),
        .dac_word_o(dac_word), .dac_valid_o(dac_valid),
        .reg_we_o(reg_we), .reg_waddr_o(reg_waddr),
        .reg_wdata_o(reg_wdata), .reg_raddr_o(reg_raddr),
        .reg_rdata_i(reg_rdata)
    );

    always @(posedge clk) begin
        if (dac_valid) dac_pulses <= dac_pulses + 1;
        if (reg_we)    we_pulses  <= we_pulses + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame: sends tx_word on din, returns the word seen on dout.
    task automatic run_frame(input logic [15:0] tx_word, output logic [15:0] rx_word,
                             output bit oe_ok);
        oe_ok = 1'b1;
        @(negedge clk);
        fs_n = 1'b0;
        din  = tx_word[15];
        wait_clk(HALF);
        rx_word[15] = dout;
        if (dout_oe !== 1'b1) oe_ok = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            if (i == 0) fs_n = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            if (i < 15) begin
                rx_word[14-i] = dout;
                if (dout_oe !== 1'b1) oe_ok = 1'b0;
                din = tx_word[14-i];
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 oe", dout_oe, 0);
        chk("R1 dout", dout, 0);
        chk("R1 dac strobe", dac_valid, 0);
        chk("R1 write strobe", reg_we, 0);
    endtask

    task automatic t_idle_clock();
        int d0 = dac_pulses, w0 = we_pulses;
        bit oe_seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            sclk = 1'b0; wait_clk(HALF); oe_seen |= dout_oe;
            sclk = 1'b1; wait_clk(HALF); oe_seen |= dout_oe;
        end
        chk("R11 oe idle", oe_seen, 0);
        chk("R11 no strobes", (dac_pulses - d0) + (we_pulses - w0), 0);
    endtask

    task automatic t_primary(input logic [15:0] adc, input logic [15:0] dac_in);
        logic [15:0] got; bit ok;
        int d0 = dac_pulses, w0 = we_pulses;
        adc_word = adc;
        run_frame(dac_in, got, ok);
        adc_word = ~adc;   // a later change must not affect the sent word
        chk("R2/R3 oe during frame", ok, 1);
        chk("R5/R3 primary word", got, adc);
        chk("R4 oe off after 16th rise", dout_oe, 0);
        wait_clk(3 * HALF);
        chk("R4 oe still off", {dout_oe, dout}, 0);
        chk("R6 dac strobe count", dac_pulses - d0, 1);
        chk("R6 dac word", dac_word, dac_in);
        chk("R6 no write strobe", we_pulses - w0, 0);
    endtask

    task automatic t_sec_write(input logic [4:0] a, input logic [7:0] d,
                               input logic [15:0] exp_out, input string req);
        logic [15:0] got; bit ok;
        int d0 = dac_pulses, w0 = we_pulses;
        logic [15:0] held = dac_word;
        run_frame({2'b11, 1'b0, a, d}, got, ok);
        wait_clk(HALF);
        chk({req, " secondary out"}, got, exp_out);
        chk("R8 write strobe count", we_pulses - w0, 1);
        chk("R8 write addr", reg_waddr, a);
        chk("R8 write data", reg_wdata, d);
        chk("R8 no dac strobe", dac_pulses - d0, 0);
        chk("R6 dac word held", dac_word, held);
    endtask

    task automatic t_sec_read(input logic [4:0] a, input logic [15:0] exp_out, input string req);
        logic [15:0] got; bit ok;
        int w0 = we_pulses;
        run_frame({2'b00, 1'b1, a, 8'hC3}, got, ok);
        wait_clk(HALF);
        chk({req, " secondary out"}, got, exp_out);
        chk("R9 read no write strobe", we_pulses - w0, 0);
        chk("R9 read addr", reg_raddr, a);
    endtask

    initial begin
        wait_clk(4);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_idle_clock();
        // R1 / R7: first frame is primary, then strict alternation
        t_primary(16'hA5C3, 16'h1E2D);
        t_sec_write(5'h11, 8'h7E, 16'h0000, "R10");
        t_primary(16'h8001, 16'hF00F);
        t_sec_read(5'h0A, 16'h0000, "R10");
        t_primary(16'h3C96, 16'h0000);
        // R9: pending read sent in the next secondary, upper byte zero
        t_sec_write(5'h03, 8'hFF, {8'h00, rd_model(5'h0A)}, "R9");
        t_primary(16'hFFFF, 16'hFFFF);
        // R10: read data is not repeated
        t_sec_write(5'h1F, 8'h00, 16'h0000, "R10");
        t_primary(16'h0001, 16'h8000);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule